// File: doc/BRIEF.md
# Hub Downstream Port Remapper

This block sits between the hub's port-level control logic and its four physical downstream ports. It turns a static configuration into translation tables. The host numbers ports 1 to N, and each enabled physical port is placed at a logical position chosen by configuration. Disabled ports are dropped from the numbering, so the host always sees a run of ports with no gaps, and the reported port count is the number of enabled ports.

Once the tables are loaded, the block works continuously. Connect status, the active-low over-current sense and the non-removable flag are routed from physical order into logical order. Port power requests are kept per logical port and routed back to the physical ports. Power can be switched individually or ganged across all enabled ports. The configuration takes effect only when a load strobe is asserted. A clash between two enabled ports asking for the same position is resolved by physical index and raises an error flag.

Top module: `port_remap_top`

## Requirements
- R1: After reset, and before the first load, the port count is 0, no logical slot is valid, every physical-to-logical entry is 0, the error flag is low, and no physical port is powered.
- R2: The position field of physical port p is `cfgOrder[2p+1:2p]`. The enabled ports are numbered 1, 2, … in ascending position. The number of physical port p appears at `p2lTable[3p+2:3p]`, and the physical index of logical port n appears at `l2pTable[2(n-1)+1:2(n-1)]`, with `l2pValid[n-1]` set.
- R3: A set bit in `cfgDisable[p]` removes port p from the numbering. Its `p2lTable` entry reads 0, the remaining ports are numbered without gaps from 1, and `portCount` equals the number of enabled ports.
- R4: When two enabled ports share a position, the lower physical index takes the lower logical number and `cfgErr` is set. A clash that involves a disabled port does not set it.
- R5: The tables, the count, the error flag and the ganged mode change only on a clock edge where `cfgLoad` is high. Configuration inputs that change without a load have no visible effect.
- R6: `logConnect[n-1]` and `logOverCur[n-1]` follow the connect input and the inverted active-low over-current input of the physical port behind logical port n. They read 0 for n above the port count.
- R7: `logFixed[n-1]` reports the non-removable flag, as captured at load, of the physical port behind logical port n.
- R8: A command with `cmdValid` high and `cmdPort` from 1 to the port count sets (`cmdOn`=1) or clears the power request of that logical port. Port 0 and numbers above the count are ignored. A load clears all power requests and takes priority over a command in the same cycle.
- R9: In individual mode (`cfgGanged`=0 at load), each enabled physical port is powered exactly when its logical port's request is set. A disabled port is never powered.
- R10: In ganged mode, every enabled physical port is powered when any logical port's request is set. Every valid logical port reports over-current when any enabled physical port senses it, and over-current on a disabled port is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Capture configuration and rebuild tables |
| cfgOrder | input | 8 | Position field per physical port, 2 bits each |
| cfgDisable | input | 4 | Per physical port disable |
| cfgFixed | input | 4 | Per physical port non-removable flag |
| cfgGanged | input | 1 | 1 = ganged power and over-current |
| cmdValid | input | 1 | Power command strobe |
| cmdPort | input | 3 | Logical port number of the command (1-based) |
| cmdOn | input | 1 | 1 = request power on, 0 = off |
| physConnect | input | 4 | Connect status, physical order |
| physOcN | input | 4 | Over-current sense, active low, physical order |
| l2pTable | output | 8 | Physical index per logical slot, 2 bits each |
| l2pValid | output | 4 | Logical slot holds a port |
| p2lTable | output | 12 | Logical number per physical port, 3 bits each, 0 = none |
| portCount | output | 3 | Number of ports reported to the host |
| cfgErr | output | 1 | Duplicate position among enabled ports |
| logConnect | output | 4 | Connect status, logical order |
| logOverCur | output | 4 | Over-current, active high, logical order |
| logFixed | output | 4 | Non-removable flag, logical order |
| physPower | output | 4 | Power enable per physical port |

## Verification
The hardest case to reach from the ports is a position clash that must resolve by physical index while other ports stay numbered correctly. Another is a command addressed past a shrunken port count, which must leave the power state untouched even though the same number was legal under the previous configuration. The stimulus loads a configuration with a deliberate duplicate position. It then reloads with two ports disabled and issues commands to port 3 and port 0, and observes `physPower` after each. Ganged over-current is exercised with the fault placed first on an enabled port and then only on a disabled one.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int PORTS = 4;
  localparam int IW = $clog2(PORTS);
  localparam int LW = $clog2(PORTS + 1);

  typedef struct packed {
    logic capture;
    logic ganged;
    logic [PORTS-1:0] powerState;
    logic [LW-1:0] portCount;
  } rm_ctl_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [PORTS-1:0] cfgDisable,
  input  logic             cfgGanged,
  input  logic             cmdValid,
  input  logic [LW-1:0]    cmdPort,
  input  logic             cmdOn,
  output rm_ctl_t          ctl
);
  logic [LW-1:0]    countQ;
  logic             gangedQ;
  logic [PORTS-1:0] powerQ;
  logic             cmdInRange;

  assign cmdInRange = cmdValid && (cmdPort != '0) && (cmdPort <= countQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      gangedQ <= 1'b0;
      powerQ  <= '0;
    end else if (cfgLoad) begin
      countQ  <= LW'($countones(~cfgDisable));
      gangedQ <= cfgGanged;
      powerQ  <= '0;
    end else if (cmdInRange) begin
      powerQ[IW'(cmdPort - LW'(1))] <= cmdOn;
    end
  end

  always_comb begin
    ctl.capture    = cfgLoad;
    ctl.ganged     = gangedQ;
    ctl.powerState = powerQ;
    ctl.portCount  = countQ;
  end

  // R8
  cmd_zero_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdPort == '0 && !cfgLoad) |=> $stable(powerQ));
  // R8
  cmd_over_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdPort > countQ && !cfgLoad) |=> $stable(powerQ));
  // R8
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (powerQ == '0));
endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rm_ctl_t             ctl,
  input  logic [PORTS*IW-1:0] cfgOrder,
  input  logic [PORTS-1:0]    cfgDisable,
  input  logic [PORTS-1:0]    cfgFixed,
  input  logic [PORTS-1:0]    physConnect,
  input  logic [PORTS-1:0]    physOcN,
  output logic [PORTS*IW-1:0] l2pTable,
  output logic [PORTS-1:0]    l2pValid,
  output logic [PORTS*LW-1:0] p2lTable,
  output logic                cfgErr,
  output logic [PORTS-1:0]    logConnect,
  output logic [PORTS-1:0]    logOverCur,
  output logic [PORTS-1:0]    logFixed,
  output logic [PORTS-1:0]    physPower
);
  logic [IW-1:0]    posV [PORTS];
  logic [LW-1:0]    rankV [PORTS];
  logic [PORTS-1:0] enV;
  logic             dupNxt;
  logic [IW-1:0]    l2pIdxNxt [PORTS];
  logic [PORTS-1:0] l2pValNxt;

  logic [IW-1:0]    l2pIdxQ [PORTS];
  logic [PORTS-1:0] l2pValQ;
  logic [LW-1:0]    p2lQ [PORTS];
  logic [PORTS-1:0] enQ;
  logic [PORTS-1:0] fixedQ;
  logic             errQ;

  // rank of each enabled port among the enabled ports
  always_comb begin
    enV    = ~cfgDisable;
    dupNxt = 1'b0;
    for (int p = 0; p < PORTS; p++) posV[p] = cfgOrder[p*IW +: IW];
    for (int p = 0; p < PORTS; p++) begin
      rankV[p] = '0;
      for (int q = 0; q < PORTS; q++)
        if (enV[q] && ((posV[q] < posV[p]) || (posV[q] == posV[p] && q < p)))
          rankV[p] = rankV[p] + LW'(1);
      for (int q = p + 1; q < PORTS; q++)
        if (enV[p] && enV[q] && posV[q] == posV[p]) dupNxt = 1'b1;
    end
    for (int i = 0; i < PORTS; i++) begin
      l2pIdxNxt[i] = '0;
      l2pValNxt[i] = 1'b0;
      for (int p = 0; p < PORTS; p++)
        if (enV[p] && rankV[p] == LW'(i)) begin
          l2pIdxNxt[i] = IW'(p);
          l2pValNxt[i] = 1'b1;
        end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PORTS; i++) begin
        l2pIdxQ[i] <= '0;
        p2lQ[i]    <= '0;
      end
      l2pValQ <= '0;
      enQ     <= '0;
      fixedQ  <= '0;
      errQ    <= 1'b0;
    end else if (ctl.capture) begin
      for (int i = 0; i < PORTS; i++) begin
        l2pIdxQ[i] <= l2pIdxNxt[i];
        p2lQ[i]    <= enV[i] ? rankV[i] + LW'(1) : '0;
      end
      l2pValQ <= l2pValNxt;
      enQ     <= enV;
      fixedQ  <= cfgFixed;
      errQ    <= dupNxt;
    end
  end

  // routing between physical and logical order
  logic ocAny;
  logic reqAny;
  assign ocAny  = |(enQ & ~physOcN);
  assign reqAny = |(ctl.powerState & l2pValQ);

  genvar g;
  generate
    for (g = 0; g < PORTS; g++) begin : g_route
      logic [IW-1:0] lIdx;
      assign lIdx          = IW'(p2lQ[g] - LW'(1));
      assign logConnect[g] = l2pValQ[g] & physConnect[l2pIdxQ[g]];
      assign logOverCur[g] = l2pValQ[g] & (ctl.ganged ? ocAny : ~physOcN[l2pIdxQ[g]]);
      assign logFixed[g]   = l2pValQ[g] & fixedQ[l2pIdxQ[g]];
      assign physPower[g]  = enQ[g] & (ctl.ganged ? reqAny : ctl.powerState[lIdx]);
      assign l2pTable[g*IW +: IW] = l2pIdxQ[g];
      assign p2lTable[g*LW +: LW] = p2lQ[g];
    end
  endgenerate

  assign l2pValid = l2pValQ;
  assign cfgErr   = errQ;

  // R5
  table_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(l2pValQ) && $stable(enQ) && $stable(errQ)));
  // R3
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(l2pValQ) == int'(ctl.portCount));
  // R9
  no_power_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (physPower & ~enQ) == '0);
  // R6
  status_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((logConnect | logOverCur | logFixed) & ~l2pValQ) == '0);
endmodule

// File: rtl/port_remap_top.sv
module port_remap_top
  import remap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoad,
  input  logic [PORTS*IW-1:0] cfgOrder,
  input  logic [PORTS-1:0]    cfgDisable,
  input  logic [PORTS-1:0]    cfgFixed,
  input  logic                cfgGanged,
  input  logic                cmdValid,
  input  logic [LW-1:0]       cmdPort,
  input  logic                cmdOn,
  input  logic [PORTS-1:0]    physConnect,
  input  logic [PORTS-1:0]    physOcN,
  output logic [PORTS*IW-1:0] l2pTable,
  output logic [PORTS-1:0]    l2pValid,
  output logic [PORTS*LW-1:0] p2lTable,
  output logic [LW-1:0]       portCount,
  output logic                cfgErr,
  output logic [PORTS-1:0]    logConnect,
  output logic [PORTS-1:0]    logOverCur,
  output logic [PORTS-1:0]    logFixed,
  output logic [PORTS-1:0]    physPower
);
  rm_ctl_t ctl;

  remap_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDisable(cfgDisable),
    .cfgGanged(cfgGanged), .cmdValid(cmdValid), .cmdPort(cmdPort),
    .cmdOn(cmdOn), .ctl(ctl)
  );

  remap_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgOrder(cfgOrder),
    .cfgDisable(cfgDisable), .cfgFixed(cfgFixed), .physConnect(physConnect),
    .physOcN(physOcN), .l2pTable(l2pTable), .l2pValid(l2pValid),
    .p2lTable(p2lTable), .cfgErr(cfgErr), .logConnect(logConnect),
    .logOverCur(logOverCur), .logFixed(logFixed), .physPower(physPower)
  );

  assign portCount = ctl.portCount;
endmodule

// File: tb/port_remap_top_tb_top.sv
`timescale 1ns/1ps
module port_remap_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [7:0] cfgOrder = '0;
  logic [3:0] cfgDisable = '0;
  logic [3:0] cfgFixed = '0;
  logic cfgGanged = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdPort = '0;
  logic cmdOn = 1'b0;
  logic [3:0] physConnect = '0;
  logic [3:0] physOcN = 4'hF;
  logic [7:0] l2pTable;
  logic [3:0] l2pValid;
  logic [11:0] p2lTable;
  logic [2:0] portCount;
  logic cfgErr;
  logic [3:0] logConnect, logOverCur, logFixed, physPower;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_remap_top dut_i (.*);

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] expP2l(input logic [7:0] ord, input logic [3:0] dis);
    logic [11:0] r = '0;
    int n = 0;
    for (int pos = 0; pos < 4; pos++)
      for (int p = 0; p < 4; p++)
        if (!dis[p] && ord[p*2 +: 2] == 2'(pos)) begin
          n++;
          r[p*3 +: 3] = 3'(n);
        end
    return r;
  endfunction

  task automatic loadCfg(input logic [7:0] ord, input logic [3:0] dis,
                         input logic [3:0] fix, input logic gang);
    @(negedge clk);
    cfgOrder = ord; cfgDisable = dis; cfgFixed = fix; cfgGanged = gang; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic sendCmd(input logic [2:0] port, input logic on);
    @(negedge clk);
    cmdValid = 1'b1; cmdPort = port; cmdOn = on;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkTables(input string req, input logic [7:0] ord, input logic [3:0] dis);
    logic [11:0] ep = expP2l(ord, dis);
    logic [7:0] el = '0;
    logic [3:0] ev = '0;
    for (int p = 0; p < 4; p++)
      if (ep[p*3 +: 3] != 0) begin
        el[(ep[p*3 +: 3] - 1) * 2 +: 2] = 2'(p);
        ev[ep[p*3 +: 3] - 1] = 1'b1;
      end
    check({req, " p2l"}, p2lTable, ep);
    check({req, " l2p"}, l2pTable, el);
    check({req, " valid"}, l2pValid, ev);
    check({req, " count"}, portCount, $countones(~dis));
  endtask

  task automatic testReset();
    physConnect = 4'hF;
    #1;
    check("R1 count", portCount, 0);
    check("R1 valid", l2pValid, 0);
    check("R1 p2l", p2lTable, 0);
    check("R1 err", cfgErr, 0);
    check("R1 power", physPower, 0);
    check("R1 connect", logConnect, 0);
  endtask

  task automatic testOrder();
    loadCfg(8'b11_10_01_00, 4'b0000, 4'b0000, 1'b0);
    checkTables("R2 identity", 8'b11_10_01_00, 4'b0000);
    check("R2 identity err", cfgErr, 0);
    loadCfg(8'b00_01_10_11, 4'b0000, 4'b0000, 1'b0);
    checkTables("R2 reversed", 8'b00_01_10_11, 4'b0000);
    check("R2 reversed p2l literal", p2lTable, {3'd1, 3'd2, 3'd3, 3'd4});
  endtask

  task automatic testDisable();
    loadCfg(8'b11_10_01_00, 4'b0110, 4'b0000, 1'b0);
    checkTables("R3 squeeze", 8'b11_10_01_00, 4'b0110);
    check("R3 p2l literal", p2lTable, {3'd2, 3'd0, 3'd0, 3'd1});
    loadCfg(8'b00_00_00_00, 4'b1111, 4'b0000, 1'b0);
    check("R3 all off count", portCount, 0);
    check("R3 all off valid", l2pValid, 0);
  endtask

  task automatic testDuplicate();
    loadCfg(8'b01_10_00_10, 4'b0000, 4'b0000, 1'b0);
    checkTables("R4 dup", 8'b01_10_00_10, 4'b0000);
    check("R4 dup p2l literal", p2lTable, {3'd2, 3'd4, 3'd1, 3'd3});
    check("R4 err set", cfgErr, 1);
    loadCfg(8'b01_10_00_10, 4'b0100, 4'b0000, 1'b0);
    check("R4 err clear with disabled clash", cfgErr, 0);
  endtask

  task automatic testHold();
    loadCfg(8'b00_01_10_11, 4'b0000, 4'b0000, 1'b0);
    @(negedge clk);
    cfgOrder = 8'b11_10_01_00; cfgDisable = 4'b1010; cfgFixed = 4'hF; cfgGanged = 1'b1;
    repeat (3) @(negedge clk);
    checkTables("R5 hold", 8'b00_01_10_11, 4'b0000);
    check("R5 hold fixed", logFixed, 0);
  endtask

  task automatic testStatus();
    loadCfg(8'b00_01_10_11, 4'b0000, 4'b0010, 1'b0);
    physConnect = 4'b0001; physOcN = 4'b1101;
    #1;
    check("R6 connect", logConnect, 4'b1000);
    check("R6 overcur", logOverCur, 4'b0100);
    check("R7 fixed", logFixed, 4'b0100);
    loadCfg(8'b11_10_01_00, 4'b1100, 4'b1111, 1'b0);
    physConnect = 4'b1111; physOcN = 4'b0011;
    #1;
    check("R6 connect gap", logConnect, 4'b0011);
    check("R6 overcur gap", logOverCur, 4'b0000);
    check("R7 fixed gap", logFixed, 4'b0011);
    physOcN = 4'hF;
  endtask

  task automatic testPower();
    loadCfg(8'b00_01_10_11, 4'b0000, 4'b0000, 1'b0);
    sendCmd(3'd1, 1'b1);
    check("R9 port1 on", physPower, 4'b1000);
    sendCmd(3'd4, 1'b1);
    check("R9 port4 on", physPower, 4'b1001);
    sendCmd(3'd0, 1'b0);
    check("R8 port0 ignored", physPower, 4'b1001);
    sendCmd(3'd5, 1'b1);
    check("R8 port5 ignored", physPower, 4'b1001);
    sendCmd(3'd1, 1'b0);
    check("R8 port1 off", physPower, 4'b0001);
    loadCfg(8'b11_10_01_00, 4'b0110, 4'b0000, 1'b0);
    check("R8 load clears", physPower, 4'b0000);
    sendCmd(3'd3, 1'b1);
    check("R8 port3 beyond count", physPower, 4'b0000);
    sendCmd(3'd2, 1'b1);
    check("R9 port2 after squeeze", physPower, 4'b1000);
  endtask

  task automatic testGanged();
    loadCfg(8'b11_10_01_00, 4'b0100, 4'b0000, 1'b1);
    check("R10 idle", physPower, 4'b0000);
    sendCmd(3'd2, 1'b1);
    check("R10 gang power", physPower, 4'b1011);
    physOcN = 4'b1110;
    #1;
    check("R10 gang oc", logOverCur, 4'b0111);
    physOcN = 4'b1011;
    #1;
    check("R10 disabled oc", logOverCur, 4'b0000);
    physOcN = 4'hF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testOrder();
    testDisable();
    testDuplicate();
    testHold();
    testStatus();
    testPower();
    testGanged();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule